// File: doc/BRIEF.md
# Root Port Status and Control Register Pair

This block holds the status and control word for each of the two root ports of a high-speed USB host controller. Each port's word reports whether a device is attached, whether that attachment has changed since software last looked, whether the port is enabled, whether a port error disabled it, and whether an overcurrent condition is present. Software reads and writes the words over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. The two change flags are cleared by writing 1 to them.

Each port has live inputs from the port hardware: device present, overcurrent, a port error seen at the end-of-frame checkpoint, a reset-complete pulse, and a flag saying that the reset found a high-speed device. Software can disable a port but can never enable it. Only a completed reset that finds a high-speed device turns a port on. Overcurrent and disconnect both force the port off. The block drives a per-port enable output that matches the enable bit.

Top module: `usb_port_status_regs`

## Requirements
- R1: After a synchronous reset with no device present, both port words read 0x00003000.
- R2: Port 0's word is at address 0x64 and port 1's word is at 0x68. Any other address reads 0. Bits 13:12 always read 1. Bits 31:14, 11:5 and every write to them have no effect and read 0.
- R3: Bit 0 (attached) equals the device-present input sampled at the previous clock edge. Writes do not change it.
- R4: Bit 1 (attach changed) is set in the cycle after any edge where device-present differs from bit 0, even if it is already set. Writing 1 to bit 1 clears it. Writing 0 leaves it unchanged.
- R5: Bit 2 (enabled) becomes 1 only after a clock edge where reset-complete, high-speed and device-present are all 1 and overcurrent is 0. A software write of 1 to bit 2 never enables the port.
- R6: A write to a port's word with bit 2 equal to 0 clears that port's enable bit, unless a hardware enable happens at the same edge.
- R7: Bit 3 (error disable) is set when a port error arrives while the port is enabled, no overcurrent is present and no disconnect is occurring. That event also clears the enable bit. Writing 1 to bit 3 clears it.
- R8: A disconnect (bit 0 is 1 and device-present is 0) clears the enable bit and does not set bit 3. Enabling the port never sets bit 3.
- R9: Bit 4 (overcurrent) equals the overcurrent input sampled at the previous edge. While overcurrent is asserted, the enable bit is cleared and cannot be set.
- R10: When a hardware set and a software write-1-clear hit bit 1 or bit 3 at the same edge, the bit ends up 1.
- R11: Each port's enable output always equals bit 2 of that port's word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dev_present | input | 2 | Device attached, one bit per port |
| ovc_in | input | 2 | Overcurrent condition, one bit per port |
| eof_err | input | 2 | Port error at end-of-frame checkpoint, per port |
| rst_done | input | 2 | Port reset sequence completed, per port |
| hs_dev | input | 2 | Reset found a high-speed device, per port |
| port_en | output | 2 | Port enabled, per port |

## Verification
The bench targets the collisions between hardware events and software writes. It lands a write-1-clear on the same edge as a new attach change or a port error; a design in which the clear wins would lose the event and leave the flag at 0. It writes 1 to the enable bit on a disabled port; a design that treats the bit as plain read-write would switch the port on. It disconnects an enabled port and then re-enables it, and it raises overcurrent during a reset-complete pulse. A design that routes every disable through the error flag, or that does not give overcurrent priority, would show bit 3 set or the port enabled where it should not be. A reference model also runs beside the design under random stimulus and both port words are compared on every clock.

// File: rtl/pstat_pkg.sv
// Package: shared bit positions, word layout and per-port state type for
// the root port status register pair. Assumes a 32-bit register bus.
package pstat_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int B_ATT    = 0;   // attached, live
    localparam int B_ATTCHG = 1;   // attach changed, write-1-clear
    localparam int B_EN     = 2;   // enabled
    localparam int B_ERRDIS = 3;   // disabled by error, write-1-clear
    localparam int B_OVC    = 4;   // overcurrent, live
    localparam logic [DATA_W-1:0] FIXED_ONES = 32'h0000_3000;

    typedef struct packed {
        logic ovc;
        logic errdis;
        logic en;
        logic attchg;
        logic att;
    } port_state_t;

    // Assemble the software-visible word from one port's state.
    function automatic logic [DATA_W-1:0] pack_word(input port_state_t s);
        logic [DATA_W-1:0] w;
        w = FIXED_ONES;
        w[B_ATT]    = s.att;
        w[B_ATTCHG] = s.attchg;
        w[B_EN]     = s.en;
        w[B_ERRDIS] = s.errdis;
        w[B_OVC]    = s.ovc;
        return w;
    endfunction
endpackage

// File: rtl/pstat_flag.sv
// Module: sticky change flag. Hardware set has priority over a software
// write-1-clear arriving at the same edge, so no event is lost.
// Assumes set_i and clr_i are single-cycle qualified strobes.
module pstat_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag: reset to 0, set wins, else clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pstat_port.sv
// Module: state of one root port. It tracks attach, overcurrent and enable,
// and raises the two change flags. Assumes wr_i is already qualified by
// address and that the inputs are synchronous to clk.
module pstat_port
    import pstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [3:1]  wbits_i,       // write data bits 3:1
    input  logic        dev_present_i,
    input  logic        ovc_i,
    input  logic        eof_err_i,
    input  logic        rst_done_i,
    input  logic        hs_dev_i,
    output port_state_t state_o,
    output logic        en_o
);
    logic att_q, ovc_q, en_q;
    logic attchg, errdis;
    logic discon, att_edge, err_kill, hw_enable, sw_disable;

    // Classify this cycle's events in priority order.
    always_comb begin
        att_edge   = dev_present_i != att_q;
        discon     = att_q && !dev_present_i;
        err_kill   = !ovc_i && !discon && eof_err_i && en_q;
        hw_enable  = !ovc_i && !discon && !err_kill && rst_done_i
                     && hs_dev_i && dev_present_i;
        sw_disable = wr_i && !wbits_i[B_EN];
    end

    // Sample live status inputs so they read as registered bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att_q <= 1'b0;
            ovc_q <= 1'b0;
        end else begin
            att_q <= dev_present_i;
            ovc_q <= ovc_i;
        end
    end

    // Enable bit: forced off by overcurrent, disconnect, error or software.
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= 1'b0;
        else if (ovc_i || discon)         en_q <= 1'b0;
        else if (err_kill)                en_q <= 1'b0;
        else if (hw_enable)               en_q <= 1'b1;
        else if (sw_disable)              en_q <= 1'b0;
    end

    pstat_flag u_attchg (
        .clk(clk), .rst_n(rst_n),
        .set_i(att_edge),
        .clr_i(wr_i && wbits_i[B_ATTCHG]),
        .flag_o(attchg)
    );

    pstat_flag u_errdis (
        .clk(clk), .rst_n(rst_n),
        .set_i(err_kill),
        .clr_i(wr_i && wbits_i[B_ERRDIS]),
        .flag_o(errdis)
    );

    // Drive the state bundle and the enable output.
    always_comb begin
        state_o.att    = att_q;
        state_o.attchg = attchg;
        state_o.en     = en_q;
        state_o.errdis = errdis;
        state_o.ovc    = ovc_q;
        en_o           = en_q;
    end

    assert_att_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (att_q == $past(dev_present_i)));
    assert_change_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_present_i != att_q) |=> attchg);
    assert_hw_only_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(rst_done_i && hs_dev_i && !ovc_i));
    assert_errdis_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(errdis) |-> $past(eof_err_i && en_q));
    assert_discon_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (att_q && !dev_present_i) |=> !en_q);
    assert_ovc_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovc_q |-> !en_q);
endmodule

// File: rtl/usb_port_status_regs.sv
// Module: top of the root port status register pair. It instantiates one
// port state block per port and decodes the register bus. Assumes
// word-aligned full-width access with reads returned combinationally.
module usb_port_status_regs
    import pstat_pkg::*;
#(
    parameter int                  NUM_PORTS = 2,
    parameter logic [ADDR_W-1:0]   BASE_ADDR = 8'h64,
    parameter int                  STRIDE    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_we,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_PORTS-1:0] dev_present,
    input  logic [NUM_PORTS-1:0] ovc_in,
    input  logic [NUM_PORTS-1:0] eof_err,
    input  logic [NUM_PORTS-1:0] rst_done,
    input  logic [NUM_PORTS-1:0] hs_dev,
    output logic [NUM_PORTS-1:0] port_en
);
    port_state_t             st  [NUM_PORTS];
    logic [NUM_PORTS-1:0]    hit;
    logic                    unused_wbits;

    assign unused_wbits = ^{reg_wdata[DATA_W-1:4], reg_wdata[0]};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(BASE_ADDR + STRIDE * p);

        // Address match for this port's word.
        always_comb hit[p] = (reg_addr == PADDR);

        pstat_port u_port (
            .clk(clk), .rst_n(rst_n),
            .wr_i(reg_we && hit[p]),
            .wbits_i(reg_wdata[3:1]),
            .dev_present_i(dev_present[p]),
            .ovc_i(ovc_in[p]),
            .eof_err_i(eof_err[p]),
            .rst_done_i(rst_done[p]),
            .hs_dev_i(hs_dev[p]),
            .state_o(st[p]),
            .en_o(port_en[p])
        );

        assert_en_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
            hit[p] |-> (reg_rdata[B_EN] == port_en[p]));
    end

    // Read mux: selected port word, zero for unmapped addresses.
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (hit[p]) reg_rdata = pack_word(st[p]);
    end

    assert_fixed_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (reg_rdata[13:12] == 2'b11 && reg_rdata[31:14] == '0));
endmodule

// File: tb/test_usb_port_status_regs.sv
module test_usb_port_status_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h64;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [1:0]  dev_present = '0, ovc_in = '0, eof_err = '0, rst_done = '0, hs_dev = '0;
    logic [1:0]  port_en;

    int vectors = 0;
    int miscompares = 0;

    // reference model state, one entry per port
    int m_att[2], m_chg[2], m_en[2], m_err[2], m_ovc[2];

    usb_port_status_regs i_usb_port_status_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .dev_present(dev_present),
        .ovc_in(ovc_in), .eof_err(eof_err), .rst_done(rst_done),
        .hs_dev(hs_dev), .port_en(port_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, updated from the stimulus seen at each edge
    always @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            bit wr, disc, chg, kill, setting;
            if (!rst_n) begin
                m_att[p] = 0; m_chg[p] = 0; m_en[p] = 0; m_err[p] = 0; m_ovc[p] = 0;
            end else begin
                wr   = reg_we && (reg_addr == 8'(8'h64 + 4*p));
                disc = (m_att[p] == 1) && !dev_present[p];
                chg  = (m_att[p] != int'(dev_present[p]));
                kill = !ovc_in[p] && !disc && eof_err[p] && (m_en[p] == 1);
                setting = !ovc_in[p] && !disc && !kill && rst_done[p] && hs_dev[p] && dev_present[p];
                if (chg) m_chg[p] = 1; else if (wr && reg_wdata[1]) m_chg[p] = 0;
                if (kill) m_err[p] = 1; else if (wr && reg_wdata[3]) m_err[p] = 0;
                if (ovc_in[p] || disc || kill) m_en[p] = 0;
                else if (setting) m_en[p] = 1;
                else if (wr && !reg_wdata[2]) m_en[p] = 0;
                m_att[p] = dev_present[p];
                m_ovc[p] = ovc_in[p];
            end
        end
    end

    function automatic logic [31:0] model_word(int p);
        return 32'h3000 | (32'(m_ovc[p]) << 4) | (32'(m_err[p]) << 3) |
               (32'(m_en[p]) << 2) | (32'(m_chg[p]) << 1) | 32'(m_att[p]);
    endfunction

    function automatic string tag_of(logic [31:0] d);
        if (d[0]) return "R3";
        if (d[1]) return "R4";
        if (d[2]) return "R5";
        if (d[3]) return "R7";
        if (d[4]) return "R9";
        return "R2";
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %08h expected %08h at %0t", tag, got, exp, $time);
        end
    endtask

    // read one word through the bus (no write in flight)
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    // compare both port words and the enable outputs against the model
    task automatic compare_all();
        logic [31:0] d;
        for (int p = 0; p < 2; p++) begin
            rd(8'(8'h64 + 4*p), d);
            check(tag_of(d ^ model_word(p)), d, model_word(p));
            check("R11", 32'(port_en[p]), 32'(m_en[p]));
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        reg_we = 1'b0;
        rst_done = '0; eof_err = '0;
        compare_all();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        tick();
    endtask

    task automatic expect_bit(string tag, int p, int b, logic v);
        logic [31:0] d;
        rd(8'(8'h64 + 4*p), d);
        check(tag, 32'(d[b]), 32'(v));
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic enable_port(int p);
        rst_done[p] = 1'b1; hs_dev[p] = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset words
        rd(8'h64, d); check("R1", d, 32'h3000);
        rd(8'h68, d); check("R1", d, 32'h3000);
        // R2: unmapped addresses read zero
        rd(8'h6C, d); check("R2", d, 32'h0);
        rd(8'h60, d); check("R2", d, 32'h0);

        // attach port 0
        dev_present[0] = 1'b1; tick();
        expect_bit("R3", 0, 0, 1'b1);
        expect_bit("R4", 0, 1, 1'b1);
        wr(8'h64, 32'h0);                     // write 0 leaves change flag
        expect_bit("R4", 0, 1, 1'b1);
        wr(8'h64, 32'h2);                     // write-1-clear
        expect_bit("R4", 0, 1, 1'b0);
        // R10: clear collides with a new attach edge
        dev_present[0] = 1'b0; wr(8'h64, 32'h2);
        expect_bit("R10", 0, 1, 1'b1);
        dev_present[0] = 1'b1; tick(); wr(8'h64, 32'h2);

        // R5: software cannot enable
        wr(8'h64, 32'h4);
        expect_bit("R5", 0, 2, 1'b0);
        enable_port(0);
        expect_bit("R5", 0, 2, 1'b1);
        check("R11", 32'(port_en[0]), 32'h1);
        // R6: software disable
        wr(8'h64, 32'h0);
        expect_bit("R6", 0, 2, 1'b0);

        // R7: error disable
        enable_port(0);
        eof_err[0] = 1'b1; tick();
        expect_bit("R7", 0, 2, 1'b0);
        expect_bit("R7", 0, 3, 1'b1);
        wr(8'h64, 32'h8);
        expect_bit("R7", 0, 3, 1'b0);
        // R10: error set collides with clear
        enable_port(0);
        eof_err[0] = 1'b1; wr(8'h64, 32'hC);
        expect_bit("R10", 0, 3, 1'b1);
        wr(8'h64, 32'hC);

        // R8: disconnect disables without error flag; enable sets no flag
        enable_port(0);
        expect_bit("R8", 0, 3, 1'b0);
        dev_present[0] = 1'b0; tick();
        expect_bit("R8", 0, 2, 1'b0);
        expect_bit("R8", 0, 3, 1'b0);
        dev_present[0] = 1'b1; tick();

        // R9: overcurrent forces off and blocks enable
        enable_port(0);
        ovc_in[0] = 1'b1; tick();
        expect_bit("R9", 0, 4, 1'b1);
        expect_bit("R9", 0, 2, 1'b0);
        enable_port(0);
        expect_bit("R9", 0, 2, 1'b0);
        ovc_in[0] = 1'b0; tick();
        expect_bit("R9", 0, 4, 1'b0);

        // R2: unimplemented bits ignore writes; port 1 independent
        wr(8'h64, 32'hFFFF_FFE0);
        rd(8'h64, d); check("R2", d & 32'hFFFF_FFE0, 32'h3000);
        dev_present[1] = 1'b1; tick();
        enable_port(1);
        expect_bit("R11", 1, 2, 1'b1);
        wr(8'h6C, 32'h0);
        expect_bit("R2", 1, 2, 1'b1);

        // random traffic compared every clock
        for (int i = 0; i < 400; i++) begin
            dev_present = ($urandom % 8 == 0) ? ~dev_present : dev_present;
            ovc_in   = ($urandom % 16 == 0) ? 2'($urandom) : ovc_in;
            eof_err  = 2'($urandom) & 2'($urandom);
            rst_done = 2'($urandom);
            hs_dev   = 2'($urandom);
            if ($urandom % 4 == 0) begin
                reg_addr  = ($urandom % 2) ? 8'h64 : 8'h68;
                reg_wdata = $urandom;
                reg_we    = 1'b1;
            end
            tick();
        end

        report();
        $finish;
    end
endmodule